// File: doc/BRIEF.md
# Framed Note-Pair Character Decoder

The block receives a stream of 3-bit note symbols, each presented together with a one-cycle valid strobe, and turns framed runs of those symbols into 8-bit ASCII characters. While no frame is open it hunts for an opening mark. Once the mark is found it takes the data symbols two at a time and maps each pair through a fixed 6x6 code book to a character, which it presents for one cycle. A closing mark ends the frame, and the block goes back to hunting.

A pair that the code book does not hold, or a broken closing mark, raises a one-cycle error pulse. Everything after that is dropped until a fresh opening mark arrives. The block sits after a note detector that has already reduced audio to a symbol index. It feeds a character sink that samples `char_o` whenever `char_valid_o` is high.

Top module: `note_stream_decoder`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `char_valid_o`, `err_o` and `char_o` are all 0, and the block is hunting for an opening mark.
- R2: A symbol is taken only in a cycle where `sym_valid_i` is 1. Whatever sits on `sym_i` in other cycles changes neither the decoded output nor any pending mark match.
- R3: The opening mark is the symbol sequence 0,7,0,7. It is found even when it overlaps a partial attempt: for example, 0,0,7,0,7 and 0,7,0,0,7,0,7 both open a frame. While hunting, no symbol produces a character or an error.
- R4: Inside a frame, data symbols are 1..6. A pair (f,s) with f != s has index (f-1)*5 + (s-1) - (s>f ? 1 : 0). Indices 0..25 decode to 'A'..'Z'. The output appears on `char_o`, with `char_valid_o` high for exactly one cycle, in the cycle after the clock edge that takes the second symbol. Otherwise `char_o` is 0.
- R5: Indices 26, 27, 28 and 29, which are the pairs (6,2), (6,3), (6,4) and (6,5), decode to '!', '.', '?' and space.
- R6: If a pair has equal symbols, if a 0 appears in either position, or if a 7 appears in the second position, `err_o` pulses for one cycle and no character is produced.
- R7: After an error, every symbol up to and including the next complete opening mark is ignored. Valid pairs and closing marks in that span produce no character and no further error.
- R8: A 7 in the first position of a pair begins a closing mark 7,0,7,0. Once it completes, the block hunts again, and the pairs that follow produce nothing.
- R9: A closing mark that starts with 7 but is broken before it completes pulses `err_o` for one cycle, and the block behaves as in R7.
- R10: `char_valid_o` and `err_o` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_valid_i | input | 1 | Symbol strobe; `sym_i` is taken when high |
| sym_i | input | 3 | Note symbol index 0..7 |
| char_o | output | 8 | Decoded ASCII character, 0 when not valid |
| char_valid_o | output | 1 | One-cycle pulse marking `char_o` |
| err_o | output | 1 | One-cycle pulse on a bad pair or broken closing mark |

## Verification
The hardest state to reach from the ports is a closing mark that breaks partway through, followed at once by traffic that would be legal in a frame. This is where the error pulse must appear once and then suppress an entire well-formed tail. The bench reaches it with directed sequences that cut 7,0,7,0 after one and after two symbols. Each cut is followed by valid pairs and a full closing mark, which must produce nothing, and then by an opening mark that overlaps a partial attempt. Valid-low gaps that carry mark-like symbols are mixed into the same runs, which shows that only strobed symbols advance the mark matchers.

// File: rtl/stream_dec_pkg.sv
package stream_dec_pkg;
  localparam int SYM_W   = 3;
  localparam int CHAR_W  = 8;
  // symbol used for framing; the other framing symbol is all-ones
  localparam int SYM_LO  = 0;
  localparam int SYM_HI  = (1 << SYM_W) - 1;
  localparam int N_DATA  = SYM_HI - 1;       // data symbols 1..N_DATA
  localparam int N_LETTR = 26;
  localparam int N_CODE  = N_DATA * (N_DATA - 1);

  typedef enum logic [2:0] {
    ST_HUNT, ST_FIRST, ST_SECOND, ST_END1, ST_END2, ST_END3
  } dec_state_e;
endpackage

// File: rtl/start_mark_finder.sv
module start_mark_finder
  import stream_dec_pkg::*;
#(
  parameter int SW = SYM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [SW-1:0] sym_i,
  output logic          hit_o
);
  localparam logic [SW-1:0] LO = SW'(SYM_LO);
  localparam logic [SW-1:0] HI = SW'(SYM_HI);

  logic [1:0] match_q, match_d;

  // overlap-aware prefix tracking for LO,HI,LO,HI
  always_comb begin
    match_d = match_q;
    hit_o   = 1'b0;
    if (clear_i) begin
      match_d = 2'd0;
    end else if (step_i) begin
      unique case (match_q)
        2'd0: match_d = (sym_i == LO) ? 2'd1 : 2'd0;
        2'd1: match_d = (sym_i == HI) ? 2'd2 : ((sym_i == LO) ? 2'd1 : 2'd0);
        2'd2: match_d = (sym_i == LO) ? 2'd3 : 2'd0;
        2'd3: begin
          if (sym_i == HI) begin
            hit_o   = 1'b1;
            match_d = 2'd0;
          end else begin
            match_d = (sym_i == LO) ? 2'd1 : 2'd0;
          end
        end
        default: match_d = 2'd0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 2'd0;
    else         match_q <= match_d;
  end
endmodule

// File: rtl/pair_codebook.sv
module pair_codebook
  import stream_dec_pkg::*;
#(
  parameter int SW = SYM_W,
  parameter int CW = CHAR_W
) (
  input  logic [SW-1:0] first_i,
  input  logic [SW-1:0] second_i,
  output logic          ok_o,
  output logic [CW-1:0] char_o
);
  int f, s, idx;

  always_comb begin
    f      = int'(first_i);
    s      = int'(second_i);
    idx    = 0;
    ok_o   = 1'b0;
    char_o = '0;
    if (f >= 1 && f <= N_DATA && s >= 1 && s <= N_DATA && f != s) begin
      // row-major over the grid with the diagonal removed
      idx = (f - 1) * (N_DATA - 1) + (s - 1) - ((s > f) ? 1 : 0);
      ok_o = 1'b1;
      if (idx < N_LETTR) begin
        char_o = CW'(65 + idx);
      end else begin
        unique case (idx - N_LETTR)
          0:       char_o = CW'(33);   // !
          1:       char_o = CW'(46);   // .
          2:       char_o = CW'(63);   // ?
          3:       char_o = CW'(32);   // space
          default: ok_o   = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/stream_ctrl.sv
module stream_ctrl
  import stream_dec_pkg::*;
#(
  parameter int SW = SYM_W,
  parameter int CW = CHAR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [SW-1:0] sym_i,
  input  logic          hit_i,
  input  logic          code_ok_i,
  input  logic [CW-1:0] code_char_i,
  output logic          hunting_o,
  output logic [SW-1:0] first_o,
  output logic [CW-1:0] char_o,
  output logic          char_valid_o,
  output logic          err_o
);
  localparam logic [SW-1:0] LO = SW'(SYM_LO);
  localparam logic [SW-1:0] HI = SW'(SYM_HI);

  dec_state_e    st_q, st_d;
  logic [SW-1:0] first_q, first_d;
  logic [CW-1:0] char_q, char_d;
  logic          cv_q, cv_d, err_q, err_d;

  always_comb begin
    st_d    = st_q;
    first_d = first_q;
    char_d  = '0;
    cv_d    = 1'b0;
    err_d   = 1'b0;
    if (valid_i) begin
      unique case (st_q)
        ST_HUNT:  if (hit_i) st_d = ST_FIRST;
        ST_FIRST: begin
          if (sym_i == HI) begin
            st_d = ST_END1;
          end else if (sym_i == LO) begin
            err_d = 1'b1;
            st_d  = ST_HUNT;
          end else begin
            first_d = sym_i;
            st_d    = ST_SECOND;
          end
        end
        ST_SECOND: begin
          if (code_ok_i) begin
            char_d = code_char_i;
            cv_d   = 1'b1;
            st_d   = ST_FIRST;
          end else begin
            err_d = 1'b1;
            st_d  = ST_HUNT;
          end
        end
        ST_END1: begin
          st_d  = (sym_i == LO) ? ST_END2 : ST_HUNT;
          err_d = (sym_i != LO);
        end
        ST_END2: begin
          st_d  = (sym_i == HI) ? ST_END3 : ST_HUNT;
          err_d = (sym_i != HI);
        end
        ST_END3: begin
          st_d  = ST_HUNT;
          err_d = (sym_i != LO);
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      first_q <= '0;
      char_q  <= '0;
      cv_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
      char_q  <= char_d;
      cv_q    <= cv_d;
      err_q   <= err_d;
    end
  end

  assign hunting_o    = (st_q == ST_HUNT);
  assign first_o      = first_q;
  assign char_o       = char_q;
  assign char_valid_o = cv_q;
  assign err_o        = err_q;
endmodule

// File: rtl/note_stream_decoder.sv
module note_stream_decoder
  import stream_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_valid_i,
  input  logic [SYM_W-1:0]  sym_i,
  output logic [CHAR_W-1:0] char_o,
  output logic              char_valid_o,
  output logic              err_o
);
  logic              hunting, hit, code_ok;
  logic [SYM_W-1:0]  first_sym;
  logic [CHAR_W-1:0] code_char;

  start_mark_finder #(.SW(SYM_W)) u_finder (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!hunting),
    .step_i (sym_valid_i && hunting),
    .sym_i  (sym_i),
    .hit_o  (hit)
  );

  pair_codebook #(.SW(SYM_W), .CW(CHAR_W)) u_book (
    .first_i (first_sym),
    .second_i(sym_i),
    .ok_o    (code_ok),
    .char_o  (code_char)
  );

  stream_ctrl #(.SW(SYM_W), .CW(CHAR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (sym_valid_i),
    .sym_i       (sym_i),
    .hit_i       (hit),
    .code_ok_i   (code_ok),
    .code_char_i (code_char),
    .hunting_o   (hunting),
    .first_o     (first_sym),
    .char_o      (char_o),
    .char_valid_o(char_valid_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/stream_dec_chk.sv
module stream_dec_chk
  import stream_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sym_valid_i,
  input logic [CHAR_W-1:0] char_o,
  input logic              char_valid_o,
  input logic              err_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!char_valid_o && !err_o && char_o == '0);
    end
  end

  // R10
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(char_valid_o && err_o));
  // R10
  cv_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |=> !char_valid_o);
  // R10
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  // R2
  no_strobe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sym_valid_i) |-> (!char_valid_o && !err_o));
  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_valid_o |-> char_o == '0);
  // R5
  legal_char_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |-> ((char_o >= 8'd65 && char_o <= 8'd90) || char_o == 8'd33 ||
                      char_o == 8'd46 || char_o == 8'd63 || char_o == 8'd32));
  // R7
  err_no_char_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !char_valid_o);
endmodule

bind note_stream_decoder stream_dec_chk u_chk (.*);

// File: tb/sim_note_stream_decoder.sv
`timescale 1ns/1ps
module sim_note_stream_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [2:0] sym = 3'd0;
  logic [7:0] ch;
  logic       cv, err;

  int checks = 0;
  int fails  = 0;
  int err_cnt = 0;
  byte got_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  note_stream_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(vld), .sym_i(sym),
    .char_o(ch), .char_valid_o(cv), .err_o(err)
  );

  always @(negedge clk) begin
    if (rst_n && cv)  got_q.push_back(ch);
    if (rst_n && err) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] s);
    sym = s; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic gap(input int n, input logic [2:0] junk);
    vld = 1'b0; sym = junk;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_start(); push(0); push(7); push(0); push(7); endtask
  task automatic send_end();   push(7); push(0); push(7); push(0); endtask

  // inverse of the code book from R4/R5
  task automatic send_char(input byte c);
    int idx, f, s;
    if (c >= "A" && c <= "Z") idx = int'(c) - 65;
    else if (c == "!") idx = 26;
    else if (c == ".") idx = 27;
    else if (c == "?") idx = 28;
    else idx = 29;
    f = idx / 5 + 1;
    s = idx % 5 + 1;
    if (s >= f) s++;
    push(3'(f)); push(3'(s));
  endtask

  task automatic send_text(input string t);
    for (int i = 0; i < t.len(); i++) send_char(t[i]);
  endtask

  task automatic expect_run(input string exp, input int exp_err, input string req);
    bit same;
    gap(2, 3'd0);
    same = (got_q.size() == exp.len());
    if (same) for (int i = 0; i < exp.len(); i++) if (got_q[i] != exp[i]) same = 0;
    chk(same, req, {"text '", exp, "' length"}, got_q.size(), exp.len());
    chk(err_cnt == exp_err, req, "error pulses", err_cnt, exp_err);
    got_q.delete();
    err_cnt = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cv && !err && ch == 8'd0, "R1", "outputs in reset", {ch, cv, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cv && !err && ch == 8'd0, "R1", "outputs after reset", {ch, cv, err}, 0);
  endtask

  task automatic t_basic();
    send_start(); push(3); push(4); push(5); push(1); push(4); push(5);
    push(2); push(5); push(1); push(4); send_end();
    expect_run("MUSIC", 0, "R4");
  endtask

  task automatic t_punct();
    send_start(); send_text("HI! OK?."); send_end();
    expect_run("HI! OK?.", 0, "R5");
  endtask

  task automatic t_timing();
    send_start();
    push(3);
    chk(!cv && ch == 8'd0, "R4", "no output after first symbol", cv, 0);
    push(4);
    chk(cv && ch == 8'd77, "R4", "char in cycle after second symbol", ch, 77);
    @(negedge clk);
    chk(!cv && ch == 8'd0, "R10", "pulse lasts one cycle", {ch, cv}, 0);
    send_end();
    expect_run("M", 0, "R4");
  endtask

  task automatic t_gaps();
    gap(2, 3'd7); push(0); gap(1, 3'd0); push(7); gap(3, 3'd7);
    push(0); gap(1, 3'd3); push(7);
    push(1); gap(2, 3'd0); push(4); gap(1, 3'd7);
    push(7); gap(2, 3'd3); push(0); push(7); gap(1, 3'd5); push(0);
    expect_run("C", 0, "R2");
  endtask

  task automatic t_overlap();
    push(1); push(7); push(6); push(0); push(7); push(7); push(3); push(4);
    expect_run("", 0, "R3");
    push(0); push(0); push(7); push(0); push(7); send_text("OK"); send_end();
    expect_run("OK", 0, "R3");
    push(0); push(7); push(0); push(0); push(7); push(0); push(7);
    send_text("Z"); send_end();
    expect_run("Z", 0, "R3");
  endtask

  task automatic t_bad_pair();
    send_start(); send_text("A"); push(3); push(3);
    send_text("BAD"); send_end(); push(2); push(5);
    expect_run("A", 1, "R6");
    send_start(); send_text("Y"); send_end();
    expect_run("Y", 0, "R7");
    send_start(); push(0); push(4); send_text("Q"); send_end();
    expect_run("", 1, "R6");
    send_start(); push(2); push(7); send_text("Q"); send_end();
    expect_run("", 1, "R6");
  endtask

  task automatic t_end();
    send_start(); send_text("E"); send_end(); send_text("XX");
    expect_run("E", 0, "R8");
    send_start(); send_text("D"); push(7); push(3); send_text("UU"); send_end();
    expect_run("D", 1, "R9");
    send_start(); send_text("F"); push(7); push(0); push(0);
    send_text("GG"); send_end();
    push(0); push(0); push(7); push(0); push(7); send_text("W"); send_end();
    expect_run("FW", 1, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_punct();
    t_timing();
    t_gaps();
    t_overlap();
    t_bad_pair();
    t_end();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule